// File: doc/BRIEF.md
# Exclusive Access Monitor

This block keeps the reservation for load-reserve/store-conditional sequences issued by a single core in a shared-memory system. An exclusive load records the granule its address falls in. A later exclusive store is allowed to write memory only when three things hold: its address lies in that same granule, the reservation is still live, and no other agent has written anywhere in the granule since the reserving load. The monitor tells the memory side whether to commit the store, and it returns a status value for the core's destination register: 0 means the store succeeded and 1 means it failed.

A snoop port reports writes made by other agents, and a clear input drops the reservation, for example on an exception return. The store decision is combinational in the cycle the store request is presented. The reservation state is updated at the following clock edge.

Top module: `excl_monitor`

## Requirements
- R1: After reset no reservation exists, so an exclusive store fails: commitEn=0 and stStatus=1.
- R2: After an exclusive load, an exclusive store in the same granule succeeds in its request cycle with commitEn=1 and stStatus=0. When no store is requested, stStatus is 0 and stStatusValid equals stExValid.
- R3: A failed store never asserts commitEn, so memory stays unchanged.
- R4: A snooped write anywhere in the reserved granule, between the load and the store, makes the store fail. A snooped write outside the granule has no effect on the reservation.
- R5: Any exclusive store clears the reservation, whether it succeeds or fails.
- R6: A new exclusive load replaces the earlier reservation. A store to the old granule then fails.
- R7: clearRes drops the reservation. It takes priority over an exclusive load in the same cycle.
- R8: The granule is 2^GRANULE_LOG2 bytes, with a default of 64. Address bits below GRANULE_LOG2 are ignored in every comparison.
- R9: A snooped write to the reserved granule in the same cycle as the store makes that store fail.
- R10: When a load and a store arrive in the same cycle, the store is judged against the old reservation. The load's granule then becomes the new reservation.
- R11: A snooped write to the load's granule in the same cycle as the load leaves no reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ldExValid | input | 1 | Exclusive load request |
| ldExAddr | input | ADDR_W | Exclusive load byte address |
| stExValid | input | 1 | Exclusive store request |
| stExAddr | input | ADDR_W | Exclusive store byte address |
| snoopWrValid | input | 1 | Write by another agent observed |
| snoopWrAddr | input | ADDR_W | Address of the observed write |
| clearRes | input | 1 | Drop the reservation |
| commitEn | output | 1 | Allow the store to write memory |
| stStatus | output | 1 | Status for the register: 0 success, 1 failure |
| stStatusValid | output | 1 | Status is meaningful this cycle |

## Verification
The bench builds the monitor with ADDR_W=16 and GRANULE_LOG2=6. With these values, addresses such as 0x13C and 0x140 fall on either side of a 64-byte boundary, and both fit in short hand-written vectors. This covers the in-granule and cross-granule cases for stores and for snoops. It also covers the same-cycle collisions: load with store, store with snoop, load with snoop, and clear with load. A small memory model in the bench writes only on commitEn, so failed stores can be seen to leave memory untouched.

// File: rtl/excl_monitor_pkg.sv
package excl_monitor_pkg;
  typedef struct packed {
    logic loadTag;   // capture the load granule
    logic setValid;  // reservation becomes live
    logic dropValid; // reservation is discarded
  } monStrobes_t;
endpackage

// File: rtl/excl_monitor_dp.sv
module excl_monitor_dp
  import excl_monitor_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int GRANULE_LOG2 = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  monStrobes_t       strobes,
  input  logic [ADDR_W-1:0] ldExAddr,
  input  logic [ADDR_W-1:0] stExAddr,
  input  logic [ADDR_W-1:0] snoopWrAddr,
  output logic              stHit,
  output logic              snoopHit,
  output logic              ldSnoopHit
);
  localparam int TAG_W = ADDR_W - GRANULE_LOG2;

  logic [TAG_W-1:0] resTag;
  logic [TAG_W-1:0] ldTag, stTag, snTag;

  assign ldTag = ldExAddr[ADDR_W-1:GRANULE_LOG2];
  assign stTag = stExAddr[ADDR_W-1:GRANULE_LOG2];
  assign snTag = snoopWrAddr[ADDR_W-1:GRANULE_LOG2];

  always_ff @(posedge clk) begin
    if (!rstN)                resTag <= '0;
    else if (strobes.loadTag) resTag <= ldTag;
  end

  assign stHit      = (stTag == resTag);
  assign snoopHit   = (snTag == resTag);
  assign ldSnoopHit = (snTag == ldTag);
endmodule

// File: rtl/excl_monitor_ctrl.sv
module excl_monitor_ctrl
  import excl_monitor_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ldExValid,
  input  logic        stExValid,
  input  logic        snoopWrValid,
  input  logic        clearRes,
  input  logic        stHit,
  input  logic        snoopHit,
  input  logic        ldSnoopHit,
  output monStrobes_t strobes,
  output logic        commitEn,
  output logic        stStatus,
  output logic        stStatusValid
);
  logic resValid;
  logic granuleDirty;

  assign granuleDirty  = snoopWrValid && snoopHit;
  assign commitEn      = stExValid && resValid && stHit && !granuleDirty;
  assign stStatus      = stExValid && !commitEn;
  assign stStatusValid = stExValid;

  always_comb begin
    strobes = '0;
    if (clearRes) begin
      strobes.dropValid = 1'b1;
    end else if (ldExValid) begin
      strobes.loadTag = 1'b1;
      if (snoopWrValid && ldSnoopHit) strobes.dropValid = 1'b1;
      else                            strobes.setValid  = 1'b1;
    end else if (stExValid || granuleDirty) begin
      strobes.dropValid = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  resValid <= 1'b0;
    else if (strobes.dropValid) resValid <= 1'b0;
    else if (strobes.setValid)  resValid <= 1'b1;
  end
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_monitor_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int GRANULE_LOG2 = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldExValid,
  input  logic [ADDR_W-1:0] ldExAddr,
  input  logic              stExValid,
  input  logic [ADDR_W-1:0] stExAddr,
  input  logic              snoopWrValid,
  input  logic [ADDR_W-1:0] snoopWrAddr,
  input  logic              clearRes,
  output logic              commitEn,
  output logic              stStatus,
  output logic              stStatusValid
);
  monStrobes_t strobes;
  logic stHit, snoopHit, ldSnoopHit;

  excl_monitor_dp #(.ADDR_W(ADDR_W), .GRANULE_LOG2(GRANULE_LOG2)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .ldExAddr(ldExAddr), .stExAddr(stExAddr), .snoopWrAddr(snoopWrAddr),
    .stHit(stHit), .snoopHit(snoopHit), .ldSnoopHit(ldSnoopHit)
  );

  excl_monitor_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .ldExValid(ldExValid), .stExValid(stExValid),
    .snoopWrValid(snoopWrValid), .clearRes(clearRes),
    .stHit(stHit), .snoopHit(snoopHit), .ldSnoopHit(ldSnoopHit),
    .strobes(strobes), .commitEn(commitEn), .stStatus(stStatus),
    .stStatusValid(stStatusValid)
  );
endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk (
  input logic clk,
  input logic rstN,
  input logic ldExValid,
  input logic stExValid,
  input logic clearRes,
  input logic commitEn,
  input logic stStatus,
  input logic stStatusValid
);
  AST_COMMIT_NEEDS_STORE: assert property (@(posedge clk) disable iff (!rstN)
    commitEn |-> stExValid); // R2
  AST_STATUS_OPPOSES_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    stStatusValid |-> (stStatus != commitEn)); // R2
  AST_CLEAR_BLOCKS_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    clearRes |=> !commitEn); // R7
  AST_STORE_CONSUMES_RES: assert property (@(posedge clk) disable iff (!rstN)
    (stExValid && !ldExValid && !clearRes) |=> !commitEn); // R5
  AST_IDLE_STATUS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !stStatusValid |-> !stStatus); // R2
endmodule

bind excl_monitor excl_monitor_chk i_chk (
  .clk(clk), .rstN(rstN), .ldExValid(ldExValid), .stExValid(stExValid),
  .clearRes(clearRes), .commitEn(commitEn), .stStatus(stStatus),
  .stStatusValid(stStatusValid)
);

// File: tb/test_excl_monitor.sv
module test_excl_monitor;
  localparam int AW = 16;
  localparam int NV = 27;
  // {ld, ldAddr, st, stAddr, snp, snpAddr, clr, expCommit}
  localparam logic [52:0] VECS [NV] = '{
    {1'b0,16'h0000,1'b1,16'h0100,1'b0,16'h0000,1'b0,1'b0}, // 0  R1 no reservation
    {1'b1,16'h0100,1'b0,16'h0000,1'b0,16'h0000,1'b0,1'b0}, // 1
    {1'b0,16'h0000,1'b1,16'h0108,1'b0,16'h0000,1'b0,1'b1}, // 2  R2 R8 same granule
    {1'b0,16'h0000,1'b1,16'h0108,1'b0,16'h0000,1'b0,1'b0}, // 3  R5 consumed
    {1'b1,16'h0100,1'b0,16'h0000,1'b0,16'h0000,1'b0,1'b0}, // 4
    {1'b0,16'h0000,1'b1,16'h0140,1'b0,16'h0000,1'b0,1'b0}, // 5  R3 R8 other granule
    {1'b1,16'h0100,1'b0,16'h0000,1'b0,16'h0000,1'b0,1'b0}, // 6
    {1'b0,16'h0000,1'b0,16'h0000,1'b1,16'h013C,1'b0,1'b0}, // 7  snoop in granule
    {1'b0,16'h0000,1'b1,16'h0100,1'b0,16'h0000,1'b0,1'b0}, // 8  R4 fails
    {1'b1,16'h0100,1'b0,16'h0000,1'b0,16'h0000,1'b0,1'b0}, // 9
    {1'b0,16'h0000,1'b0,16'h0000,1'b1,16'h0140,1'b0,1'b0}, // 10 snoop outside
    {1'b0,16'h0000,1'b1,16'h013F,1'b0,16'h0000,1'b0,1'b1}, // 11 R4 R8 still ok
    {1'b1,16'h0200,1'b0,16'h0000,1'b0,16'h0000,1'b0,1'b0}, // 12
    {1'b1,16'h0300,1'b0,16'h0000,1'b0,16'h0000,1'b0,1'b0}, // 13
    {1'b0,16'h0000,1'b1,16'h0200,1'b0,16'h0000,1'b0,1'b0}, // 14 R6 old granule
    {1'b1,16'h0300,1'b0,16'h0000,1'b0,16'h0000,1'b0,1'b0}, // 15
    {1'b0,16'h0000,1'b1,16'h0300,1'b0,16'h0000,1'b0,1'b1}, // 16 R6 new granule
    {1'b1,16'h0100,1'b0,16'h0000,1'b0,16'h0000,1'b0,1'b0}, // 17
    {1'b0,16'h0000,1'b0,16'h0000,1'b0,16'h0000,1'b1,1'b0}, // 18 clear
    {1'b0,16'h0000,1'b1,16'h0100,1'b0,16'h0000,1'b0,1'b0}, // 19 R7
    {1'b1,16'h0100,1'b0,16'h0000,1'b0,16'h0000,1'b0,1'b0}, // 20
    {1'b0,16'h0000,1'b1,16'h0100,1'b1,16'h0120,1'b0,1'b0}, // 21 R9
    {1'b1,16'h0100,1'b0,16'h0000,1'b0,16'h0000,1'b0,1'b0}, // 22
    {1'b1,16'h0200,1'b1,16'h0100,1'b0,16'h0000,1'b0,1'b1}, // 23 R10 old judged
    {1'b0,16'h0000,1'b1,16'h0200,1'b0,16'h0000,1'b0,1'b1}, // 24 R10 new live
    {1'b1,16'h0100,1'b0,16'h0000,1'b0,16'h0000,1'b1,1'b0}, // 25 clear beats load
    {1'b0,16'h0000,1'b1,16'h0100,1'b0,16'h0000,1'b0,1'b0}  // 26 R7
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ldExValid = 1'b0, stExValid = 1'b0, snoopWrValid = 1'b0, clearRes = 1'b0;
  logic [AW-1:0] ldExAddr = '0, stExAddr = '0, snoopWrAddr = '0;
  logic commitEn, stStatus, stStatusValid;
  int checks = 0, errors = 0;
  logic [7:0] mem [16];
  logic [7:0] stData = '0;

  always #5 clk = ~clk;

  excl_monitor #(.ADDR_W(AW), .GRANULE_LOG2(6)) i_excl_monitor (
    .clk(clk), .rstN(rstN), .ldExValid(ldExValid), .ldExAddr(ldExAddr),
    .stExValid(stExValid), .stExAddr(stExAddr), .snoopWrValid(snoopWrValid),
    .snoopWrAddr(snoopWrAddr), .clearRes(clearRes), .commitEn(commitEn),
    .stStatus(stStatus), .stStatusValid(stStatusValid)
  );

  always_ff @(posedge clk) if (commitEn) mem[stExAddr[9:6]] <= stData;

  task automatic check(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic idle();
    ldExValid = 0; stExValid = 0; snoopWrValid = 0; clearRes = 0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'hAA;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    #2;
    check("R1", commitEn, 1'b0, "reset commit");
    check("R2", stStatus, 1'b0, "reset idle status");
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      {ldExValid, ldExAddr, stExValid, stExAddr, snoopWrValid, snoopWrAddr,
       clearRes} = VECS[v][52:1];
      #2;
      check($sformatf("vec%0d R1-R11", v), commitEn, VECS[v][0], "commit");
      check($sformatf("vec%0d R2", v), stStatus,
            stExValid && !VECS[v][0], "status");
      check($sformatf("vec%0d R2", v), stStatusValid, stExValid, "status valid");
    end
    // R3: failed store leaves memory untouched, successful one writes
    @(negedge clk); idle();
    stExValid = 1; stExAddr = 16'h0080; stData = 8'h55;
    @(negedge clk); idle(); #2;
    check("R3", mem[2] == 8'hAA, 1'b1, "memory unchanged");
    ldExValid = 1; ldExAddr = 16'h0080;
    @(negedge clk); idle();
    stExValid = 1; stExAddr = 16'h0084; stData = 8'h66;
    @(negedge clk); idle(); #2;
    check("R2", mem[2] == 8'h66, 1'b1, "memory written");
    // R11: load with snoop to its granule in the same cycle
    ldExValid = 1; ldExAddr = 16'h0400; snoopWrValid = 1; snoopWrAddr = 16'h0410;
    @(negedge clk); idle();
    stExValid = 1; stExAddr = 16'h0400; #2;
    check("R11", commitEn, 1'b0, "load with snoop");
    // R1: reset drops a live reservation
    @(negedge clk); idle();
    ldExValid = 1; ldExAddr = 16'h0500;
    @(negedge clk); idle(); rstN = 0;
    @(negedge clk); rstN = 1;
    stExValid = 1; stExAddr = 16'h0500; #2;
    check("R1", commitEn, 1'b0, "after reset");
    check("R1", stStatus, 1'b1, "after reset status");
    @(negedge clk); idle();
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule